// File: doc/BRIEF.md
# Two-Pad Serial Controller Port

This block is the console-side logic for two eight-button gamepads on a small CPU bus, together with a cycle-level model of the parallel-in/serial-out register inside each pad. Software writes a control register to raise and drop a latch line shared by both pads. Raising and dropping that line captures every button. Software then reads one of two port addresses eight times, and each read returns one button on data bit 0.

A read is destructive: it also shifts the register of the pad that was read. The serial line from each pad reaches the bus through an inverting buffer whose unused inputs are pulled high. Bits 4 to 1 therefore read as 0, and a pressed button reads as 1. Bits 7 to 5 are not driven during a port read. They return whatever the bus last carried, which a bus-hold register tracks from CPU writes, from bytes that other agents drive (for example instruction fetches) and from earlier port reads. The same control write also sets two general-purpose output lines.

Top module: `pad_port_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after reset, strobe_o and gpo_o are 0, rdata_o is 0 and both oe_n_o bits are 1.
- R2: A write (wr_i) to address PORT_BASE sets strobe_o to wdata_i[0] and gpo_o to wdata_i[2:1], visible from the cycle after the write.
- R3: A write to any other address, including PORT_BASE+1, leaves strobe_o and gpo_o unchanged.
- R4: oe_n_o[k] is low only in a cycle where rd_i is high and addr_i equals PORT_BASE+k, and at most one bit is low at a time.
- R5: After strobe_o goes high and then low, eight reads of pad k return buttons_i[k*8+n] on rdata_o[0] for n = 0..7 in that order (1 = pressed), using the button levels present when the strobe fell. rdata_o updates in the cycle after the read.
- R6: Reads of one pad do not advance the other pad's register.
- R7: While strobe_o is high, every read of pad k returns the live level of buttons_i[k*8] on bit 0.
- R8: After eight reads following a strobe, further reads of that pad return 1 on bit 0.
- R9: Bits 4 to 1 of every port read are 0.
- R10: Bits 7 to 5 of a port read equal bits 7 to 5 of the last byte on the bus before it: write data, an observed byte (bus_obs_vld_i) or the previous port read result.
- R11: rdata_o changes only on a port read. Reads of other addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Port read result, registered |
| bus_obs_i | input | 8 | Byte driven on the bus by another agent |
| bus_obs_vld_i | input | 1 | bus_obs_i is valid this cycle |
| buttons_i | input | N_PADS*N_BTN | Button levels, 1 = pressed, pad k at bits k*N_BTN and up |
| strobe_o | output | 1 | Latch line to both pads |
| gpo_o | output | GPO_W | General-purpose outputs from the control write |
| oe_n_o | output | N_PADS | Per-pad output enable, active low |

## Verification
The bench sweeps many button patterns for both pads and interleaves reads of the two pads. It changes the buttons after the strobe falls, so a design that keeps reloading, or that shares one shift register between the pads, returns the wrong bit sequence. It reads past the eighth button to catch a design that shifts in 0 or wraps around. It also reads while the strobe is high to catch a design that shifts there instead of reloading. Before every read a different byte is placed on the bus, so a design that drives fixed upper bits, or that forgets to track writes or earlier port reads, shows the wrong value in bits 7 to 5.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned DRIVEN_W = 5;
  typedef logic [DATA_W-1:0] bus_byte_t;
endpackage

// File: rtl/pad_port_decode.sv
module pad_port_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_PADS = 2,
  parameter logic [ADDR_W-1:0] PORT_BASE = 'h4016
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              ctl_wr_o,
  output logic [N_PADS-1:0] rd_sel_o,
  output logic [N_PADS-1:0] oe_n_o
);
  assign ctl_wr_o = wr_i && (addr_i == PORT_BASE);

  for (genvar k = 0; k < N_PADS; k++) begin : g_sel
    localparam logic [ADDR_W-1:0] PAD_ADDR = PORT_BASE + ADDR_W'(k);
    assign rd_sel_o[k] = rd_i && (addr_i == PAD_ADDR);
    assign oe_n_o[k]   = ~rd_sel_o[k];
  end
endmodule

// File: rtl/pad_sipo_model.sv
module pad_sipo_model #(
  parameter int unsigned N_BTN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [N_BTN-1:0] buttons_i,
  output logic             ser_n_o
);
  // Held as pressed = 1; the serial pin is active low.
  logic [N_BTN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= buttons_i;
    else if (shift_i) sr_q <= {1'b1, sr_q[N_BTN-1:1]};
  end

  // Transparent while loading: the first button follows the live input.
  assign ser_n_o = load_i ? ~buttons_i[0] : ~sr_q[0];
endmodule

// File: rtl/pad_bus_hold.sv
module pad_bus_hold import pad_port_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  bus_byte_t wdata_i,
  input  logic      port_rd_i,
  input  bus_byte_t rd_byte_i,
  input  logic      obs_vld_i,
  input  bus_byte_t obs_i,
  output bus_byte_t hold_o
);
  bus_byte_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= '0;
    else if (wr_i)      hold_q <= wdata_i;
    else if (port_rd_i) hold_q <= rd_byte_i;
    else if (obs_vld_i) hold_q <= obs_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/pad_port_ctrl.sv
module pad_port_ctrl import pad_port_pkg::*; #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_PADS = 2,
  parameter int unsigned N_BTN  = 8,
  parameter int unsigned GPO_W  = 2,
  parameter logic [ADDR_W-1:0] PORT_BASE = 'h4016
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      wr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      rd_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [DATA_W-1:0]         bus_obs_i,
  input  logic                      bus_obs_vld_i,
  input  logic [N_PADS*N_BTN-1:0]   buttons_i,
  output logic                      strobe_o,
  output logic [GPO_W-1:0]          gpo_o,
  output logic [N_PADS-1:0]         oe_n_o
);
  localparam int unsigned FLOAT_W = DATA_W - DRIVEN_W;

  logic              ctl_wr;
  logic [N_PADS-1:0] rd_sel;
  logic [N_PADS-1:0] ser_n;
  logic              port_rd;
  logic              strobe_q;
  logic [GPO_W-1:0]  gpo_q;
  logic [DRIVEN_W-1:0] buf_out [N_PADS];
  logic [DRIVEN_W-1:0] rd_low;
  bus_byte_t         hold;
  bus_byte_t         rd_byte;
  bus_byte_t         rdata_q;

  pad_port_decode #(
    .ADDR_W(ADDR_W), .N_PADS(N_PADS), .PORT_BASE(PORT_BASE)
  ) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .ctl_wr_o(ctl_wr), .rd_sel_o(rd_sel), .oe_n_o(oe_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      gpo_q    <= '0;
    end else if (ctl_wr) begin
      strobe_q <= wdata_i[0];
      gpo_q    <= wdata_i[GPO_W:1];
    end
  end

  for (genvar k = 0; k < N_PADS; k++) begin : g_pad
    pad_sipo_model #(.N_BTN(N_BTN)) u_pad (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(strobe_q), .shift_i(rd_sel[k]),
      .buttons_i(buttons_i[k*N_BTN +: N_BTN]),
      .ser_n_o(ser_n[k])
    );
    // Inverting buffer, spare inputs pulled high.
    assign buf_out[k] = ~{{(DRIVEN_W-1){1'b1}}, ser_n[k]};
  end

  always_comb begin
    rd_low = '0;
    for (int k = 0; k < N_PADS; k++)
      if (rd_sel[k]) rd_low = rd_low | buf_out[k];
  end

  assign port_rd = |rd_sel;
  assign rd_byte = {hold[DATA_W-1 -: FLOAT_W], rd_low};

  pad_bus_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_i), .wdata_i(wdata_i),
    .port_rd_i(port_rd), .rd_byte_i(rd_byte),
    .obs_vld_i(bus_obs_vld_i), .obs_i(bus_obs_i),
    .hold_o(hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (port_rd) rdata_q <= rd_byte;
  end

  assign rdata_o  = rdata_q;
  assign strobe_o = strobe_q;
  assign gpo_o    = gpo_q;
endmodule

// File: rtl/pad_port_chk.sv
module pad_port_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_PADS = 2,
  parameter int unsigned N_BTN  = 8,
  parameter int unsigned GPO_W  = 2,
  parameter logic [ADDR_W-1:0] PORT_BASE = 'h4016
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       addr_i,
  input logic                    wr_i,
  input logic [7:0]              wdata_i,
  input logic                    rd_i,
  input logic [7:0]              rdata_o,
  input logic [N_PADS*N_BTN-1:0] buttons_i,
  input logic                    strobe_o,
  input logic [GPO_W-1:0]        gpo_o,
  input logic [N_PADS-1:0]       oe_n_o
);
  logic [ADDR_W-1:0] off;
  logic ctl_wr, any_rd, rd0;
  assign off    = addr_i - PORT_BASE;
  assign ctl_wr = wr_i && (addr_i == PORT_BASE);
  assign any_rd = rd_i && (off < ADDR_W'(N_PADS));
  assign rd0    = rd_i && (addr_i == PORT_BASE);

  assert_ctl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> (strobe_o == $past(wdata_i[0])) && (gpo_o == $past(wdata_i[GPO_W:1])));

  assert_ctl_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr |=> $stable(strobe_o) && $stable(gpo_o));

  assert_oe_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~oe_n_o));

  assert_oe_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_rd |-> (oe_n_o == '1));

  assert_live_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && rd0) |=> (rdata_o[0] == $past(buttons_i[0])));

  assert_low_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rd |=> (rdata_o[4:1] == 4'b0000));

  assert_rdata_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_rd |=> $stable(rdata_o));
endmodule

bind pad_port_ctrl pad_port_chk #(
  .ADDR_W(ADDR_W), .N_PADS(N_PADS), .N_BTN(N_BTN), .GPO_W(GPO_W), .PORT_BASE(PORT_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .rd_i(rd_i), .rdata_o(rdata_o), .buttons_i(buttons_i), .strobe_o(strobe_o),
  .gpo_o(gpo_o), .oe_n_o(oe_n_o)
);

// File: tb/pad_port_ctrl_test.sv
module pad_port_ctrl_test;
  localparam logic [15:0] BASE = 16'h4016;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0, obs_vld = 1'b0;
  logic [7:0]  wdata = '0, obs = '0;
  logic [15:0] buttons = '0;
  logic [7:0]  rdata;
  logic        strobe;
  logic [1:0]  gpo, oe_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pad_port_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .bus_obs_i(obs), .bus_obs_vld_i(obs_vld),
    .buttons_i(buttons), .strobe_o(strobe), .gpo_o(gpo), .oe_n_o(oe_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_obs(input logic [7:0] d);
    @(negedge clk); obs = d; obs_vld = 1'b1;
    @(negedge clk); obs_vld = 1'b0;
  endtask

  task automatic port_read(input logic [15:0] a, output logic [7:0] r, output logic [1:0] oe);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 oe = oe_n;
    @(negedge clk); rd = 1'b0;
    r = rdata;
  endtask

  task automatic check_read(input int k, input bit exp_bit, input logic [2:0] exp_up, input string req);
    logic [7:0] r;
    logic [1:0] oe;
    logic [1:0] exp_oe;
    port_read(BASE + 16'(k), r, oe);
    exp_oe = (k == 0) ? 2'b10 : 2'b01;
    chk(r[0] == exp_bit, req, "bit0", 32'(r[0]), 32'(exp_bit));
    chk(r[4:1] == 4'b0, "R9", "bits4:1", 32'(r[4:1]), 0);
    chk(r[7:5] == exp_up, "R10", "bits7:5", 32'(r[7:5]), 32'(exp_up));
    chk(oe == exp_oe, "R4", "oe_n", 32'(oe), 32'(exp_oe));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, snap;
    logic [1:0] oe;
    logic [7:0] b0, b1, v;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(strobe == 1'b0, "R1", "strobe", 32'(strobe), 0);
    chk(gpo == 2'b00, "R1", "gpo", 32'(gpo), 0);
    chk(rdata == 8'h00, "R1", "rdata", 32'(rdata), 0);
    chk(oe_n == 2'b11, "R1", "oe_n", 32'(oe_n), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe == 1'b0 && gpo == 2'b00, "R1", "post-reset ctl", 32'({strobe, gpo}), 0);

    // R2 control writes
    bus_write(BASE, 8'h06);
    chk(strobe == 1'b0, "R2", "strobe", 32'(strobe), 0);
    chk(gpo == 2'b11, "R2", "gpo", 32'(gpo), 3);
    bus_write(BASE, 8'h03);
    chk(strobe == 1'b1, "R2", "strobe", 32'(strobe), 1);
    chk(gpo == 2'b01, "R2", "gpo", 32'(gpo), 1);

    // R3 writes elsewhere are ignored
    bus_write(BASE + 16'd1, 8'h04);
    chk(strobe == 1'b1 && gpo == 2'b01, "R3", "second port write", 32'({strobe, gpo}), 32'b101);
    bus_write(16'h2000, 8'hF8);
    chk(strobe == 1'b1 && gpo == 2'b01, "R3", "other addr write", 32'({strobe, gpo}), 32'b101);

    // R7 strobe held high: live first button
    for (int i = 0; i < 4; i++) begin
      buttons = {8'h00, 7'h00, i[0]};
      bus_obs(8'h40);
      check_read(0, i[0], 3'b010, "R7");
    end
    bus_write(BASE, 8'h00);

    // Sweep of button patterns, R5 R6 R8 R10
    for (int p = 0; p < 24; p++) begin
      b0 = 8'((p * 37 + 11) ^ (p << 3));
      b1 = 8'((p * 91 + 5));
      if (p == 0) begin b0 = 8'h00; b1 = 8'hFF; end
      if (p == 1) begin b0 = 8'hFF; b1 = 8'h00; end
      buttons = {b1, b0};
      bus_write(BASE, {5'b0, 2'(p), 1'b1});
      chk(gpo == 2'(p), "R2", "gpo sweep", 32'(gpo), 32'(2'(p)));
      bus_write(BASE, {5'b0, 2'(p), 1'b0});
      buttons = ~{b1, b0};  // captured values must persist
      for (int n = 0; n < 10; n++) begin
        v = 8'(p * 29 + n * 53 + 7);
        bus_obs(v);
        check_read(0, (n < 8) ? b0[n] : 1'b1, v[7:5], (n < 8) ? "R5" : "R8");
        // no new bus byte: previous port read supplies the upper bits
        check_read(1, (n < 8) ? b1[n] : 1'b1, v[7:5], (n < 8) ? "R6" : "R8");
      end
    end

    // R10 write data feeds the bus hold
    buttons = 16'h0001;
    bus_write(BASE, 8'h01);
    bus_write(BASE, 8'h00);
    bus_write(16'h3000, 8'hE0);
    check_read(0, 1'b1, 3'b111, "R5");
    bus_write(16'h3000, 8'hA0);
    check_read(1, 1'b0, 3'b101, "R6");

    // R11 reads of other addresses leave rdata and oe alone
    snap = rdata;
    port_read(16'h4018, r, oe);
    chk(r == snap, "R11", "rdata after non-port read", 32'(r), 32'(snap));
    chk(oe == 2'b11, "R4", "oe_n non-port read", 32'(oe), 3);
    bus_obs(8'hFF);
    chk(rdata == snap, "R11", "rdata after bus byte", 32'(rdata), 32'(snap));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule